// File: doc/BRIEF.md
# Instruction Breakpoint and Single-Step Controller

This block halts a CPU for a debugger. It watches the address of every instruction's leading opcode fetch. When that fetch hits an armed breakpoint address, or when a pending single-step stop is set, it raises a halt toward the core. The halt is held until the debugger releases it. A debug transport writes an 8-bit control register, which has no read path, and loads four 24-bit breakpoint address registers through separate write ports.

The control register sits at debug write address 0x10. Bit 7 (`step_stop`) stops the core before the next instruction. Writing a 0 to bit 7 is the only way to release a halt. Bits 6, 5, 4 and 3 arm breakpoints 3, 2, 1 and 0 in that order. Bits 2..0 are ignored.

A strap is sampled on the last reset cycle. If the debug clock pin level is high and the debug data pin level is low, `step_stop` leaves reset set, so the first instruction is stopped. Each stop sets `step_stop` again in hardware, which keeps the core halted until the debugger clears the bit.

Top module: `dbg_break_unit`

## Requirements
- R1: Reset clears `halt` and `break_req`. With the strap inactive and no breakpoint armed, a leading opcode fetch after reset raises no break.
- R2: A strap of debug clock pin high and debug data pin low on the last reset cycle makes the first leading opcode fetch after reset break. Any other strap combination does not.
- R3: Writing a value with bit 7 = 1 to control address 0x10 makes the next leading opcode fetch break, whatever its address.
- R4: Breakpoint k is armed by control bit 3+k. A leading fetch whose 24-bit address equals an armed breakpoint register in all bits breaks.
- R5: A fetch address that differs in any bit from every armed breakpoint, or that matches only a disarmed one, does not break.
- R6: A fetch with `fetch_first` low never breaks, even when its address matches or bit 7 is set.
- R7: A break sets `halt` in the cycle after the fetch. `halt` stays high through idle cycles and through control writes with bit 7 = 1. It falls in the cycle after a control write with bit 7 = 0.
- R8: `break_req` is high for exactly one cycle per break, in the same cycle that `halt` rises.
- R9: Several armed breakpoints matching the same fetch produce a single one-cycle `break_req`.
- R10: Writes to any address other than 0x10 leave the control register unchanged, and bits 2..0 of a control write have no effect.
- R11: While halted, leading fetch strobes raise no further `break_req`.
- R12: Releasing a halt clears the single-step stop. The next leading fetch breaks only if it hits an armed breakpoint, and the same breakpoint fires again on a later fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Debug register write strobe |
| ctl_wr_addr | input | 8 | Debug register write address |
| ctl_wr_data | input | 8 | Debug register write data |
| bp_wr_en | input | 1 | Breakpoint address load strobe |
| bp_wr_sel | input | 2 | Breakpoint register to load |
| bp_wr_addr | input | 24 | Breakpoint address value |
| fetch_addr | input | 24 | CPU opcode fetch address |
| fetch_first | input | 1 | High on the leading opcode fetch of an instruction |
| strap_clk_lvl | input | 1 | Sampled debug clock pin level |
| strap_data_lvl | input | 1 | Sampled debug data pin level |
| break_req | output | 1 | One-cycle pulse when a break is taken |
| halt | output | 1 | Holds the CPU while in break |

## Verification
Both outputs are registered.

- A fetch presented with `fetch_first` in cycle N shows its verdict on `break_req` and `halt` in cycle N+1.
- A control write in cycle N changes `halt` in cycle N+1.
- Its arming bits are first used by a fetch in cycle N+1 or later.
- A breakpoint load in cycle N is compared from cycle N+1.

The bench drives each stimulus for one cycle on the falling edge and samples on the next falling edge, which is exactly one rising edge later. No fetch ever shares a cycle with the write that configures it.

// File: rtl/dbg_break_pkg.sv
package dbg_break_pkg;
  localparam int unsigned BP_ADDR_W    = 24;
  localparam int unsigned BP_COUNT     = 4;
  localparam int unsigned DBG_ADDR_W   = 8;
  localparam int unsigned DBG_DATA_W   = 8;
  localparam logic [7:0]  CTL_REG_ADDR = 8'h10;
  localparam int unsigned STEP_BIT     = 7;
endpackage

// File: rtl/bp_addr_bank.sv
module bp_addr_bank #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned COUNT  = 4,
  localparam int unsigned SEL_W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [ADDR_W-1:0]       wr_addr,
  output logic [COUNT*ADDR_W-1:0] bp_flat
);
  // Registers rather than RAM: all entries are compared in the same cycle.
  for (genvar k = 0; k < COUNT; k++) begin : g_bp
    logic [ADDR_W-1:0] addr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(k))) begin
        addr_q <= wr_addr;
      end
    end
    assign bp_flat[k*ADDR_W +: ADDR_W] = addr_q;
  end
endmodule

// File: rtl/bp_compare.sv
module bp_compare #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned COUNT  = 4
) (
  input  logic [COUNT*ADDR_W-1:0] bp_flat,
  input  logic [COUNT-1:0]        bp_arm,
  input  logic [ADDR_W-1:0]       fetch_addr,
  output logic                    any_hit
);
  logic [COUNT-1:0] hit_vec;

  for (genvar k = 0; k < COUNT; k++) begin : g_cmp
    assign hit_vec[k] = bp_arm[k] && (bp_flat[k*ADDR_W +: ADDR_W] == fetch_addr);
  end

  // Simultaneous hits merge into one break; no priority is needed.
  assign any_hit = |hit_vec;
endmodule

// File: rtl/break_ctrl.sv
module break_ctrl #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned COUNT    = 4,
  parameter int unsigned STEP_POS = 7,
  localparam int unsigned ARM_LSB = STEP_POS - COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_data,
  input  logic              fetch_first,
  input  logic              any_hit,
  input  logic              strap_clk_lvl,
  input  logic              strap_data_lvl,
  output logic [COUNT-1:0]  bp_arm,
  output logic              break_req,
  output logic              halt
);
  logic step_q;
  logic halt_q;
  logic req_q;
  logic [COUNT-1:0] arm_q;
  logic trigger;

  assign trigger = fetch_first && !halt_q && (step_q || any_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      // The strap level seen on the last reset cycle decides the step bit.
      step_q <= strap_clk_lvl && !strap_data_lvl;
      arm_q  <= '0;
      halt_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (ctl_wr) begin
        step_q <= ctl_data[STEP_POS];
        arm_q  <= ctl_data[ARM_LSB +: COUNT];
      end
      if (trigger) begin
        halt_q <= 1'b1;
        req_q  <= 1'b1;
        step_q <= 1'b1;
      end else if (halt_q && ctl_wr && !ctl_data[STEP_POS]) begin
        halt_q <= 1'b0;
      end
    end
  end

  assign bp_arm    = arm_q;
  assign break_req = req_q;
  assign halt      = halt_q;
endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit
  import dbg_break_pkg::*;
#(
  parameter int unsigned ADDR_W   = BP_ADDR_W,
  parameter int unsigned COUNT    = BP_COUNT,
  parameter int unsigned RADDR_W  = DBG_ADDR_W,
  parameter int unsigned DATA_W   = DBG_DATA_W,
  parameter logic [7:0]  CTL_ADDR = CTL_REG_ADDR,
  localparam int unsigned SEL_W   = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_wr_en,
  input  logic [RADDR_W-1:0] ctl_wr_addr,
  input  logic [DATA_W-1:0]  ctl_wr_data,
  input  logic               bp_wr_en,
  input  logic [SEL_W-1:0]   bp_wr_sel,
  input  logic [ADDR_W-1:0]  bp_wr_addr,
  input  logic [ADDR_W-1:0]  fetch_addr,
  input  logic               fetch_first,
  input  logic               strap_clk_lvl,
  input  logic               strap_data_lvl,
  output logic               break_req,
  output logic               halt
);
  logic [COUNT*ADDR_W-1:0] bp_flat;
  logic [COUNT-1:0]        bp_arm;
  logic                    any_hit;
  logic                    ctl_wr;

  assign ctl_wr = ctl_wr_en && (ctl_wr_addr == RADDR_W'(CTL_ADDR));

  bp_addr_bank #(.ADDR_W(ADDR_W), .COUNT(COUNT)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bp_wr_en),
    .wr_sel  (bp_wr_sel),
    .wr_addr (bp_wr_addr),
    .bp_flat (bp_flat)
  );

  bp_compare #(.ADDR_W(ADDR_W), .COUNT(COUNT)) u_cmp (
    .bp_flat    (bp_flat),
    .bp_arm     (bp_arm),
    .fetch_addr (fetch_addr),
    .any_hit    (any_hit)
  );

  break_ctrl #(.DATA_W(DATA_W), .COUNT(COUNT), .STEP_POS(STEP_BIT)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .ctl_wr         (ctl_wr),
    .ctl_data       (ctl_wr_data),
    .fetch_first    (fetch_first),
    .any_hit        (any_hit),
    .strap_clk_lvl  (strap_clk_lvl),
    .strap_data_lvl (strap_data_lvl),
    .bp_arm         (bp_arm),
    .break_req      (break_req),
    .halt           (halt)
  );
endmodule

// File: rtl/dbg_break_unit_chk.sv
module dbg_break_unit_chk #(
  parameter int unsigned RADDR_W  = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [7:0]  CTL_ADDR = 8'h10
) (
  input logic               clk,
  input logic               rst,
  input logic               ctl_wr_en,
  input logic [RADDR_W-1:0] ctl_wr_addr,
  input logic [DATA_W-1:0]  ctl_wr_data,
  input logic               fetch_first,
  input logic               break_req,
  input logic               halt
);
  logic clr_wr;
  assign clr_wr = ctl_wr_en && (ctl_wr_addr == RADDR_W'(CTL_ADDR)) && !ctl_wr_data[7];

  AST_REQ_WITH_HALT: assert property (@(posedge clk) disable iff (rst)
    break_req |-> halt); // R8
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    break_req |=> !break_req); // R8
  AST_RISE_ON_FETCH: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> $past(fetch_first)); // R6
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halt && !clr_wr) |=> halt); // R7
  AST_HALT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (halt && clr_wr) |=> !halt); // R7
  AST_NO_REQ_HALTED: assert property (@(posedge clk) disable iff (rst)
    (halt && !clr_wr) |=> !break_req); // R11
endmodule

bind dbg_break_unit dbg_break_unit_chk #(
  .RADDR_W (RADDR_W),
  .DATA_W  (DATA_W),
  .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_wr_en   (ctl_wr_en),
  .ctl_wr_addr (ctl_wr_addr),
  .ctl_wr_data (ctl_wr_data),
  .fetch_first (fetch_first),
  .break_req   (break_req),
  .halt        (halt)
);

// File: tb/dbg_break_unit_tb.sv
module dbg_break_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr_en = 1'b0;
  logic [7:0]  ctl_wr_addr = 8'h00;
  logic [7:0]  ctl_wr_data = 8'h00;
  logic        bp_wr_en = 1'b0;
  logic [1:0]  bp_wr_sel = 2'd0;
  logic [23:0] bp_wr_addr = 24'h0;
  logic [23:0] fetch_addr = 24'h0;
  logic        fetch_first = 1'b0;
  logic        strap_clk_lvl = 1'b0;
  logic        strap_data_lvl = 1'b0;
  logic        break_req;
  logic        halt;

  int checks = 0;
  int fails  = 0;

  dbg_break_unit u_dut (
    .clk(clk), .rst(rst),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_addr(ctl_wr_addr), .ctl_wr_data(ctl_wr_data),
    .bp_wr_en(bp_wr_en), .bp_wr_sel(bp_wr_sel), .bp_wr_addr(bp_wr_addr),
    .fetch_addr(fetch_addr), .fetch_first(fetch_first),
    .strap_clk_lvl(strap_clk_lvl), .strap_data_lvl(strap_data_lvl),
    .break_req(break_req), .halt(halt)
  );

  always #5 clk = ~clk;

  localparam logic [23:0] A0 = 24'h001000;
  localparam logic [23:0] A1 = 24'h00ABCD;
  localparam logic [23:0] A2 = 24'hFFFFFF;
  localparam logic [23:0] A3 = 24'h800000;

  // Each entry: {fetch address, break expected}.
  localparam logic [24:0] VEC [8] = '{
    {A0, 1'b1}, {24'h001001, 1'b0}, {A1, 1'b1}, {24'h10ABCD, 1'b0},
    {A2, 1'b1}, {24'h7FFFFF, 1'b0}, {A3, 1'b1}, {24'h000000, 1'b0}
  };

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] a, input logic [7:0] d);
    ctl_wr_en = 1'b1; ctl_wr_addr = a; ctl_wr_data = d;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic bp_load(input logic [1:0] s, input logic [23:0] a);
    bp_wr_en = 1'b1; bp_wr_sel = s; bp_wr_addr = a;
    @(negedge clk);
    bp_wr_en = 1'b0;
  endtask

  task automatic fetch(input logic [23:0] a, input logic first);
    fetch_addr = a; fetch_first = first;
    @(negedge clk);
    fetch_first = 1'b0;
  endtask

  task automatic do_reset(input logic sc, input logic sd);
    rst = 1'b1; strap_clk_lvl = sc; strap_data_lvl = sd;
    repeat (3) @(negedge clk);
    rst = 1'b0; strap_clk_lvl = 1'b0; strap_data_lvl = 1'b1;
  endtask

  initial begin
    #(20000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0, 1'b0);
    chk(halt, 1'b0, "R1 halt after reset");
    chk(break_req, 1'b0, "R1 req after reset");
    fetch(24'h000123, 1'b1);
    chk(break_req, 1'b0, "R1 no break after plain reset");

    // Forced single-step stop.
    ctl_write(8'h10, 8'h80);
    fetch(24'h000200, 1'b0);
    chk(halt, 1'b0, "R6 non-leading fetch ignores step");
    fetch(24'h000201, 1'b1);
    chk(break_req, 1'b1, "R3 forced break req");
    chk(halt, 1'b1, "R3 forced break halt");
    idle();
    chk(break_req, 1'b0, "R8 req lasts one cycle");
    chk(halt, 1'b1, "R7 halt held idle");
    fetch(24'h000202, 1'b1);
    chk(break_req, 1'b0, "R11 no req while halted");
    ctl_write(8'h10, 8'h80);
    chk(halt, 1'b1, "R7 write bit7=1 keeps halt");
    ctl_write(8'h10, 8'h00);
    chk(halt, 1'b0, "R7 release on bit7=0");
    fetch(24'h000203, 1'b1);
    chk(break_req, 1'b0, "R12 step cleared by release");

    // Table of address matches with all breakpoints armed.
    bp_load(2'd0, A0); bp_load(2'd1, A1); bp_load(2'd2, A2); bp_load(2'd3, A3);
    ctl_write(8'h10, 8'h78);
    for (int i = 0; i < 8; i++) begin
      fetch(VEC[i][24:1], 1'b1);
      chk(break_req, VEC[i][0], VEC[i][0] ? "R4 armed match req" : "R5 mismatch req");
      chk(halt, VEC[i][0], VEC[i][0] ? "R4 armed match halt" : "R5 mismatch halt");
      if (VEC[i][0]) begin
        ctl_write(8'h10, 8'h78);
        chk(halt, 1'b0, "R7 release in table");
      end
    end
    fetch(A1, 1'b1);
    chk(break_req, 1'b1, "R12 same breakpoint fires again");
    ctl_write(8'h10, 8'h78);

    // Only breakpoint 3 armed (bit 6).
    ctl_write(8'h10, 8'h40);
    fetch(A0, 1'b1);
    chk(halt, 1'b0, "R5 disarmed match ignored");
    fetch(A3, 1'b1);
    chk(halt, 1'b1, "R4 bit6 arms breakpoint 3");
    ctl_write(8'h10, 8'h40);

    // Two breakpoints on one address.
    bp_load(2'd1, A0);
    ctl_write(8'h10, 8'h78);
    fetch(A0, 1'b1);
    chk(break_req, 1'b1, "R9 double match req");
    idle();
    chk(break_req, 1'b0, "R9 double match single pulse");
    ctl_write(8'h10, 8'h78);

    // Non-leading fetch at a matching address.
    fetch(A0, 1'b0);
    chk(halt, 1'b0, "R6 non-leading match ignored");

    // Reserved bits and foreign addresses.
    ctl_write(8'h10, 8'h07);
    fetch(A0, 1'b1);
    chk(halt, 1'b0, "R10 reserved bits arm nothing");
    ctl_write(8'h11, 8'hF8);
    fetch(A0, 1'b1);
    chk(halt, 1'b0, "R10 other address ignored");

    // Strap at reset.
    do_reset(1'b1, 1'b0);
    chk(halt, 1'b0, "R2 no halt before first fetch");
    fetch(24'h000000, 1'b1);
    chk(break_req, 1'b1, "R2 strap breaks first instruction");
    ctl_write(8'h10, 8'h00);
    do_reset(1'b1, 1'b1);
    fetch(24'h000000, 1'b1);
    chk(break_req, 1'b0, "R2 strap data high no break");
    do_reset(1'b0, 1'b0);
    fetch(24'h000000, 1'b1);
    chk(break_req, 1'b0, "R2 strap clock low no break");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule